// File: doc/BRIEF.md
# Dual Supply Ready Monitor

This block decides whether a gate driver channel may switch. It receives two digitized supply readings, each an unsigned millivolt code: one for the low-voltage control-side rail and one for the positive rail of the driver side. It also receives an over-temperature flag. Each rail passes through its own hysteretic check, which has a separate qualify level and a separate drop level. The negative driver-side rail is not watched.

The block merges the checks into a single registered ready line, active high, that can model an open-drain release. A control-side undervoltage or an over-temperature pulls ready low at once and holds it there. A driver-side undervoltage works differently. It must persist for a programmable number of cycles, and then it produces one ready-low pulse of bounded length per episode. The drive path is disabled whenever a qualifying condition is lost. It is re-enabled only after ready has been back, with the driver-side rail good, for a programmable number of cycles. While enabled, the gate output follows the drive command.

Top module: `ready_mon`

## Requirements
- R1: While reset is held, and in the cycle after it, `rdy`, `drive_en` and `gate_out` are 0.
- R2: The control-side rail qualifies at a code of `VIN_ON_MV` (3000) or above and drops below `VIN_OFF_MV` (2400). Codes between the two levels keep the previous state. A drop makes `rdy` low two cycles after the sample.
- R3: The driver-side rail qualifies at `VOUT_ON_MV` (13500) or above and drops below `VOUT_OFF_MV` (12500). Codes between the two levels keep the previous state. A drop clears `drive_en` and `gate_out` two cycles after the sample.
- R4: After the driver-side check drops, `rdy` stays high until `FALL_DLY` cycles have passed. It then goes low for exactly `PULSE_LEN` cycles and is released again, even if the rail is still low. This happens only once per episode.
- R5: A driver-side dip that recovers before `FALL_DLY` cycles have passed produces no ready-low pulse.
- R6: An over-temperature flag sampled high forces `rdy`, `drive_en` and `gate_out` low on the next cycle.
- R7: `drive_en` rises exactly `EN_DLY` cycles after `rdy` returns, provided the driver-side rail stays good. It drops in the same cycle that `rdy` drops.
- R8: While `drive_en` is high, `gate_out` equals `drive_cmd` delayed by one cycle.
- R9: `gate_out` is never high while `rdy` is low.
- R10: After reset, `rdy` stays low while the driver-side rail has not yet qualified, even if the control-side rail is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_mv | input | MV_W | Control-side supply reading, millivolts |
| vout_mv | input | MV_W | Driver-side positive supply reading, millivolts |
| overtemp | input | 1 | Over-temperature flag, active high |
| drive_cmd | input | 1 | Gate command from the controller |
| rdy | output | 1 | Ready, high = released |
| drive_en | output | 1 | Drive path enabled |
| gate_out | output | 1 | Gated drive command |

## Verification
Each rail is stepped to codes just inside its hysteresis band, then one code past each level. This separates a correct hysteretic check from a single-threshold comparator or from an off-by-one in a bound. The driver-side rail is given two kinds of drop: a sustained one, which must produce one ready-low pulse at the exact delay and length, and a short dip, which must produce none. The difference between the two shows the persistence counter and the once-per-episode arming. Over-temperature, command toggling and a start-up with only the control-side rail present show which inputs gate ready and which gate only the enable path.

// File: rtl/ready_mon_pkg.sv
package ready_mon_pkg;

  // Index of each watched rail inside the check array.
  localparam int SUP_IN  = 0;
  localparam int SUP_OUT = 1;
  localparam int N_SUP   = 2;

  // Width of a counter that must hold values 0..n.
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/supply_hyst_chk.sv
module supply_hyst_chk #(
  parameter int MV_W   = 16,
  parameter int ON_MV  = 3000,
  parameter int OFF_MV = 2400
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MV_W-1:0] mv,
  output logic            good
);

  localparam logic [MV_W-1:0] ON_C  = MV_W'(ON_MV);
  localparam logic [MV_W-1:0] OFF_C = MV_W'(OFF_MV);

  logic good_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q <= 1'b0;
    end else if (!good_q && (mv >= ON_C)) begin
      good_q <= 1'b1;
    end else if (good_q && (mv < OFF_C)) begin
      good_q <= 1'b0;
    end
  end

  assign good = good_q;

  // R2 / R3: reaching the qualify level sets the flag on the next cycle
  a_r2_r3_turn_on: assert property (@(posedge clk) disable iff (rst)
    (mv >= ON_C) |=> good_q);

  // R2 / R3: a qualified rail inside the band stays qualified
  a_r2_r3_band_hold: assert property (@(posedge clk) disable iff (rst)
    (good_q && (mv >= OFF_C)) |=> good_q);

  // R2 / R3: below the drop level the flag is clear on the next cycle
  a_r2_r3_turn_off: assert property (@(posedge clk) disable iff (rst)
    (mv < OFF_C) |=> !good_q);

endmodule

// File: rtl/dip_pulse_gen.sv
module dip_pulse_gen
  import ready_mon_pkg::*;
#(
  parameter int FALL_DLY  = 1000,
  parameter int PULSE_LEN = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic good,
  output logic low_req
);

  localparam int DW = cnt_w(FALL_DLY);
  localparam int PW = cnt_w(PULSE_LEN);
  localparam logic [DW-1:0] DLY_LAST = DW'(FALL_DLY - 1);
  localparam logic [PW-1:0] PLEN     = PW'(PULSE_LEN);

  logic [DW-1:0] dly_cnt;
  logic [PW-1:0] pls_cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_cnt <= '0;
      pls_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      if (pls_cnt != '0) begin
        pls_cnt <= pls_cnt - PW'(1);
      end
      if (good) begin
        dly_cnt <= '0;
        armed   <= 1'b1;
      end else if (armed) begin
        if (dly_cnt == DLY_LAST) begin
          dly_cnt <= '0;
          armed   <= 1'b0;
          pls_cnt <= PLEN;
        end else begin
          dly_cnt <= dly_cnt + DW'(1);
        end
      end
    end
  end

  assign low_req = (pls_cnt != '0);

  // R4: the pulse never exceeds its bound
  a_r4_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
    pls_cnt <= PLEN);

  // R5: a good rail starts no new pulse; a running one only drains
  a_r5_no_start_when_good: assert property (@(posedge clk) disable iff (rst)
    good |=> (pls_cnt == '0) || (pls_cnt == $past(pls_cnt) - PW'(1)));

endmodule

// File: rtl/en_delay.sv
module en_delay
  import ready_mon_pkg::*;
#(
  parameter int EN_DLY = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic qual,
  output logic en
);

  localparam int CW = cnt_w(EN_DLY);
  localparam logic [CW-1:0] CMAX = CW'(EN_DLY);

  logic [CW-1:0] cnt;
  logic          en_q;

  always_ff @(posedge clk) begin
    if (rst || !qual) begin
      cnt  <= '0;
      en_q <= 1'b0;
    end else if (!en_q) begin
      if (cnt == CMAX) begin
        en_q <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign en = en_q;

  // R7: losing qualification drops the enable on the next cycle
  a_r7_drop_follows: assert property (@(posedge clk) disable iff (rst)
    !qual |=> !en_q);

endmodule

// File: rtl/ready_mon.sv
module ready_mon
  import ready_mon_pkg::*;
#(
  parameter int MV_W        = 16,
  parameter int VIN_ON_MV   = 3000,
  parameter int VIN_OFF_MV  = 2400,
  parameter int VOUT_ON_MV  = 13500,
  parameter int VOUT_OFF_MV = 12500,
  parameter int FALL_DLY    = 1000,
  parameter int PULSE_LEN   = 25,
  parameter int EN_DLY      = 100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MV_W-1:0] vin_mv,
  input  logic [MV_W-1:0] vout_mv,
  input  logic            overtemp,
  input  logic            drive_cmd,
  output logic            rdy,
  output logic            drive_en,
  output logic            gate_out
);

  logic [N_SUP-1:0] good;
  logic             low_req;
  logic             boot_ok;
  logic             rdy_next;
  logic             qual;
  logic             rdy_q;
  logic             gate_q;
  logic             en_w;

  for (genvar i = 0; i < N_SUP; i++) begin : g_sup
    localparam int ON_L  = (i == SUP_IN) ? VIN_ON_MV  : VOUT_ON_MV;
    localparam int OFF_L = (i == SUP_IN) ? VIN_OFF_MV : VOUT_OFF_MV;
    supply_hyst_chk #(
      .MV_W  (MV_W),
      .ON_MV (ON_L),
      .OFF_MV(OFF_L)
    ) u_chk (
      .clk (clk),
      .rst (rst),
      .mv  ((i == SUP_IN) ? vin_mv : vout_mv),
      .good(good[i])
    );
  end

  dip_pulse_gen #(
    .FALL_DLY (FALL_DLY),
    .PULSE_LEN(PULSE_LEN)
  ) u_dip (
    .clk    (clk),
    .rst    (rst),
    .good   (good[SUP_OUT]),
    .low_req(low_req)
  );

  // Driver-side rail must qualify once after reset before ready (R10).
  always_ff @(posedge clk) begin
    if (rst) begin
      boot_ok <= 1'b0;
    end else if (good[SUP_OUT]) begin
      boot_ok <= 1'b1;
    end
  end

  assign rdy_next = good[SUP_IN] && (boot_ok || good[SUP_OUT]) &&
                    !overtemp && !low_req;
  assign qual     = rdy_next && good[SUP_OUT];

  en_delay #(
    .EN_DLY(EN_DLY)
  ) u_en (
    .clk (clk),
    .rst (rst),
    .qual(qual),
    .en  (en_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      rdy_q  <= rdy_next;
      gate_q <= qual && en_w && drive_cmd;
    end
  end

  assign rdy      = rdy_q;
  assign drive_en = en_w;
  assign gate_out = gate_q;

  // R9: gate only while ready is released
  a_r9_gate_needs_rdy: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> rdy_q);

  // R7: enable implies ready
  a_r7_en_needs_rdy: assert property (@(posedge clk) disable iff (rst)
    en_w |-> rdy_q);

  // R6: over-temperature clears ready next cycle
  a_r6_overtemp_drop: assert property (@(posedge clk) disable iff (rst)
    overtemp |=> !rdy_q);

  // R2: a disqualified control-side rail clears ready next cycle
  a_r2_vin_drop: assert property (@(posedge clk) disable iff (rst)
    !good[SUP_IN] |=> !rdy_q);

  // R3: a disqualified driver-side rail clears the gate next cycle
  a_r3_vout_gate: assert property (@(posedge clk) disable iff (rst)
    !good[SUP_OUT] |=> !gate_q);

endmodule

// File: tb/ready_mon_bench.sv
module ready_mon_bench;

  localparam int MV_W = 16;
  localparam int F    = 20;
  localparam int P    = 5;
  localparam int D    = 10;
  localparam int SIG_RDY  = 0;
  localparam int SIG_EN   = 1;
  localparam int SIG_GATE = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [MV_W-1:0] vin_mv = '0;
  logic [MV_W-1:0] vout_mv = '0;
  logic            overtemp = 1'b0;
  logic            drive_cmd = 1'b0;
  logic            rdy, drive_en, gate_out;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int    at;
    int    sig;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  ready_mon #(
    .MV_W(MV_W), .VIN_ON_MV(3000), .VIN_OFF_MV(2400),
    .VOUT_ON_MV(13500), .VOUT_OFF_MV(12500),
    .FALL_DLY(F), .PULSE_LEN(P), .EN_DLY(D)
  ) u_ready_mon (
    .clk(clk), .rst(rst), .vin_mv(vin_mv), .vout_mv(vout_mv),
    .overtemp(overtemp), .drive_cmd(drive_cmd),
    .rdy(rdy), .drive_en(drive_en), .gate_out(gate_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: push an expectation dt cycles ahead (dt >= 1)
  task automatic exp_chk(input int dt, input int sig, input bit val, input string tag);
    exp_t e;
    e.at = cyc + dt; e.sig = sig; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic exp_all(input int dt, input bit r, input bit e, input bit g, input string tag);
    exp_chk(dt, SIG_RDY, r, tag);
    exp_chk(dt, SIG_EN, e, tag);
    exp_chk(dt, SIG_GATE, g, tag);
  endtask

  task automatic advance(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare due expectations away from the active edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        logic act;
        act = (sb[i].sig == SIG_RDY) ? rdy :
              (sb[i].sig == SIG_EN)  ? drive_en : gate_out;
        checks++;
        if (act !== sb[i].val) begin
          errors++;
          $display("FAIL %s sig=%0d cycle=%0d actual=%0b expected=%0b",
                   sb[i].tag, sb[i].sig, cyc, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    advance(1);
    exp_all(1, 0, 0, 0, "R1 in reset");
    advance(3);
    rst = 1'b0;
    exp_all(1, 0, 0, 0, "R1 after reset");
    advance(2);

    // R10: control side good, driver side absent
    vin_mv = 16'd3300; drive_cmd = 1'b1;
    exp_chk(3, SIG_RDY, 0, "R10 no driver rail");
    exp_chk(6, SIG_RDY, 0, "R10 no driver rail late");
    advance(8);

    // R7 start-up enable timing
    vout_mv = 16'd15000;
    exp_chk(2, SIG_RDY, 1, "R7 rdy up");
    exp_chk(1 + D, SIG_EN, 0, "R7 en early");
    exp_chk(2 + D, SIG_EN, 1, "R7 en on time");
    exp_chk(3 + D, SIG_GATE, 1, "R8 gate on");
    advance(D + 8);

    // R8 command following
    drive_cmd = 1'b0;
    exp_chk(1, SIG_GATE, 0, "R8 cmd low");
    exp_chk(1, SIG_EN, 1, "R8 en kept");
    advance(3);
    drive_cmd = 1'b1;
    exp_chk(1, SIG_GATE, 1, "R8 cmd high");
    advance(3);

    // R2 control-side hysteresis
    vin_mv = 16'd2600;
    exp_chk(3, SIG_RDY, 1, "R2 inside band");
    advance(4);
    vin_mv = 16'd2399;
    exp_chk(1, SIG_RDY, 1, "R2 before drop");
    exp_all(2, 0, 0, 0, "R2 R9 drop");
    advance(4);
    vin_mv = 16'd2999;
    exp_chk(3, SIG_RDY, 0, "R2 below qualify");
    advance(4);
    vin_mv = 16'd3000;
    exp_chk(2, SIG_RDY, 1, "R2 qualify");
    exp_chk(2 + D, SIG_EN, 1, "R7 re-enable");
    advance(D + 6);

    // R3 / R4 driver-side hysteresis and delayed pulse
    vout_mv = 16'd13000;
    exp_chk(3, SIG_EN, 1, "R3 inside band");
    advance(4);
    vout_mv = 16'd12499;
    exp_chk(1, SIG_EN, 1, "R3 before drop");
    exp_chk(2, SIG_EN, 0, "R3 en drop");
    exp_chk(2, SIG_GATE, 0, "R3 gate drop");
    exp_chk(2, SIG_RDY, 1, "R4 rdy held");
    exp_chk(1 + F, SIG_RDY, 1, "R4 before pulse");
    exp_chk(2 + F, SIG_RDY, 0, "R4 pulse start");
    exp_chk(2 + F, SIG_GATE, 0, "R9 gate in pulse");
    exp_chk(1 + F + P, SIG_RDY, 0, "R4 pulse end");
    exp_chk(2 + F + P, SIG_RDY, 1, "R4 released");
    exp_chk(12 + F + P, SIG_RDY, 1, "R4 single pulse");
    advance(F + P + 15);
    vout_mv = 16'd13499;
    exp_chk(3, SIG_EN, 0, "R3 below qualify");
    advance(4);
    vout_mv = 16'd13500;
    exp_chk(1 + D, SIG_EN, 0, "R7 en early");
    exp_chk(2 + D, SIG_EN, 1, "R3 R7 qualify");
    advance(D + 6);

    // R5 brief dip
    vout_mv = 16'd12000;
    advance(5);
    vout_mv = 16'd14000;
    exp_chk(F - 2, SIG_RDY, 1, "R5 no pulse");
    exp_chk(F + 2, SIG_RDY, 1, "R5 no pulse late");
    exp_chk(1 + D, SIG_EN, 0, "R5 en waits");
    exp_chk(2 + D, SIG_EN, 1, "R5 en back");
    advance(F + D + 6);

    // R6 over-temperature
    overtemp = 1'b1;
    exp_all(1, 0, 0, 0, "R6 overtemp");
    advance(5);
    overtemp = 1'b0;
    exp_chk(1, SIG_RDY, 1, "R6 cleared");
    exp_chk(D, SIG_EN, 0, "R7 en early");
    exp_chk(1 + D, SIG_EN, 1, "R6 R7 en back");
    advance(D + 6);

    advance(5);
    if (sb.size() != 0) begin
      errors += sb.size();
      $display("FAIL pending expectations actual=%0d expected=0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule